// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Test-Port Sharing

This block is an eight-pin digital I/O port that sits on a microcontroller peripheral bus. Software reaches four registers through a single-cycle module/index bus: output data, direction, synchronized pin levels, and a control register. A pin set as an output drives its output data bit. A pin set as an input drives nothing, and the same output data bit then turns on the pin's weak pullup. Because the pullup enable shares that bit, software sets both the driven level and the pullup with one write.

Pins 0 to 3 are shared with a boundary-scan test port. After reset they belong to that test port: pin 0 carries its serial data out, and pins 1, 2 and 3 feed its mode-select, data-in and clock inputs. Software hands those four pins to general-purpose use by setting the release bit in the control register.

Pad levels pass through a per-pin synchronizer before software reads them. The synchronized levels of pins 4 to 7 also go out as taps to the ADC conversion-start input, the DAC load input and two timer inputs. These taps are valid whatever the pin direction is.

Top module: `gpio_mux_port`

## Requirements
- R1: Each register is 16 bits wide on the bus, and only its low byte holds state. The upper byte of every register reads 0, and writing it has no effect. The control register holds bit 0 only; its other bits read 0.
- R2: Reset sets output data (index 0) to 0x00FF, direction (index 1) to 0x0000 and control (index 2 is input, index 3 is control) to 0x0000. A read of output data returns the stored value, not the pad level.
- R3: A general-purpose pin whose direction bit is 1 has pad_oe=1, pad_out equal to its output data bit, and pad_pu=0.
- R4: A general-purpose pin whose direction bit is 0 has pad_oe=0 and pad_out=0, and pad_pu equals its output data bit. pad_oe and pad_pu are never both 1 on the same pin.
- R5: Writing the direction register never changes the contents of the output data register.
- R6: While control bit 0 is 0, pins 0 to 3 belong to the test port, whatever the output data and direction registers hold. Pin 0 has pad_oe=1, pad_out=jtag_tdo and pad_pu=0. Pins 1 to 3 have pad_oe=0 and pad_pu=0. jtag_tms, jtag_tdi and jtag_tck follow pad_in[1], pad_in[2] and pad_in[3] without delay.
- R7: While control bit 0 is 1, pins 0 to 3 behave as general-purpose pins (R3, R4). jtag_tms and jtag_tdi are held at 1, and jtag_tck is held at 0.
- R8: Index 2 reads pad_in[7:0] through two flops. A pad change shows up at the second rising clock edge after it occurs. Reading index 2 has no side effect, and writing it has no effect.
- R9: tap_adc_start, tap_dac_load, tap_tmr0 and tap_tmr1 equal the synchronized levels of pins 4, 5, 6 and 7, whatever the direction setting.
- R10: An access whose bus_mod differs from the MODULE_ID parameter (default 0), or whose index is above 3, reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mod | input | 4 | Module select of the access |
| bus_idx | input | 4 | Register index within the module |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 16 | Write data; only the low byte is stored |
| bus_rdata | output | 16 | Combinational read data for bus_mod/bus_idx |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Weak pullup enables |
| jtag_tdo | input | 1 | Serial data out from the test port |
| jtag_tms | output | 1 | Mode select to the test port |
| jtag_tdi | output | 1 | Serial data in to the test port |
| jtag_tck | output | 1 | Clock to the test port |
| tap_adc_start | output | 1 | Synchronized level of pin 4 |
| tap_dac_load | output | 1 | Synchronized level of pin 5 |
| tap_tmr0 | output | 1 | Synchronized level of pin 6 |
| tap_tmr1 | output | 1 | Synchronized level of pin 7 |

## Verification
The latency assertion on the synchronizer assumes that pad_in is stable around each rising edge, so that a one-edge capture is well defined. The bench meets this by changing pad_in, bus signals and jtag_tdo only on falling edges. The bus assertions assume bus_wr is a clean single-cycle strobe. The bench raises it for exactly one rising edge per write. Every bus read is sampled shortly after a falling edge, once the combinational read path has settled.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   // register indices inside the module
   localparam int unsigned IDX_ODATA = 0;
   localparam int unsigned IDX_DIR   = 1;
   localparam int unsigned IDX_PIN   = 2;
   localparam int unsigned IDX_CTRL  = 3;
   // pins shared with the test port, lowest first: data-out, mode, data-in, clock
   localparam int unsigned SHARED_PINS = 4;
   localparam int unsigned TAP_PINS    = 4;
endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) st[s] <= '0;
      end else begin
         st[0] <= d;
         for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];

   generate
      if (STAGES == 2) begin : g_lat_chk
         logic [1:0] warm;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) warm <= '0;
            else if (warm != 2'd2) warm <= warm + 2'd1;
         end
         assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (warm == 2'd2) |-> (q == $past(d, 2)));
      end
   endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS = 8,
   parameter int unsigned BUS_W = 16,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   input  logic [BUS_W-1:0] wdata,
   input  logic [NPINS-1:0] pin_sync,
   output logic [BUS_W-1:0] rdata,
   output logic [NPINS-1:0] odata,
   output logic [NPINS-1:0] dir,
   output logic             released
);
   logic hit_odata, hit_dir, hit_pin, hit_ctrl;

   assign hit_odata = sel && (idx == IDX_W'(IDX_ODATA));
   assign hit_dir   = sel && (idx == IDX_W'(IDX_DIR));
   assign hit_pin   = sel && (idx == IDX_W'(IDX_PIN));
   assign hit_ctrl  = sel && (idx == IDX_W'(IDX_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         odata    <= '1;
         dir      <= '0;
         released <= 1'b0;
      end else if (wr) begin
         if (hit_odata) odata    <= wdata[NPINS-1:0];
         if (hit_dir)   dir      <= wdata[NPINS-1:0];
         if (hit_ctrl)  released <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_odata)     rdata[NPINS-1:0] = odata;
      else if (hit_dir)  rdata[NPINS-1:0] = dir;
      else if (hit_pin)  rdata[NPINS-1:0] = pin_sync;
      else if (hit_ctrl) rdata[0]         = released;
   end

   assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[BUS_W-1:NPINS] == '0);
   assert_dir_keeps_odata_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_dir) |=> $stable(odata));
   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_odata || hit_dir || hit_pin || hit_ctrl) |-> (rdata == '0));
endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS = 8
) (
   input  logic [NPINS-1:0] odata,
   input  logic [NPINS-1:0] dir,
   input  logic             released,
   input  logic [NPINS-1:0] pad_in,
   input  logic             jtag_tdo,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_pu,
   output logic             jtag_tms,
   output logic             jtag_tdi,
   output logic             jtag_tck
);
   genvar g;
   generate
      for (g = 0; g < NPINS; g++) begin : g_pin
         logic gp_oe, gp_out, gp_pu;
         assign gp_oe  = dir[g];
         assign gp_out = dir[g] & odata[g];
         assign gp_pu  = ~dir[g] & odata[g];
         if (g < SHARED_PINS) begin : g_shared
            localparam bit IS_DOUT = (g == 0);
            assign pad_oe[g]  = released ? gp_oe  : IS_DOUT;
            assign pad_out[g] = released ? gp_out : (IS_DOUT ? jtag_tdo : 1'b0);
            assign pad_pu[g]  = released ? gp_pu  : 1'b0;
         end else begin : g_plain
            assign pad_oe[g]  = gp_oe;
            assign pad_out[g] = gp_out;
            assign pad_pu[g]  = gp_pu;
         end
      end
   endgenerate

   // test-port inputs park at idle levels once the pins are released
   assign jtag_tms = released ? 1'b1 : pad_in[1];
   assign jtag_tdi = released ? 1'b1 : pad_in[2];
   assign jtag_tck = released ? 1'b0 : pad_in[3];
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned BUS_W       = 16,
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned MOD_W       = 4,
   parameter int unsigned MODULE_ID   = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MOD_W-1:0] bus_mod,
   input  logic [IDX_W-1:0] bus_idx,
   input  logic             bus_wr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_pu,
   input  logic             jtag_tdo,
   output logic             jtag_tms,
   output logic             jtag_tdi,
   output logic             jtag_tck,
   output logic             tap_adc_start,
   output logic             tap_dac_load,
   output logic             tap_tmr0,
   output logic             tap_tmr1
);
   localparam int unsigned TAP_BASE = NPINS - TAP_PINS;

   generate
      if (NPINS != SHARED_PINS + TAP_PINS) begin : g_bad_npins
         $error("NPINS must equal shared pins plus tap pins");
      end
      if (BUS_W <= NPINS) begin : g_bad_bus
         $error("BUS_W must exceed NPINS");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("IDX_W must be at least 2");
      end
   endgenerate

   logic             sel;
   logic [NPINS-1:0] pin_sync;
   logic [NPINS-1:0] odata, dir;
   logic             released;

   assign sel = (bus_mod == MOD_W'(MODULE_ID));

   gpio_port_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
   );

   gpio_port_regs #(.NPINS(NPINS), .BUS_W(BUS_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr), .idx(bus_idx),
      .wdata(bus_wdata), .pin_sync(pin_sync), .rdata(bus_rdata),
      .odata(odata), .dir(dir), .released(released)
   );

   gpio_port_pinmux #(.NPINS(NPINS)) u_mux (
      .odata(odata), .dir(dir), .released(released), .pad_in(pad_in),
      .jtag_tdo(jtag_tdo), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi), .jtag_tck(jtag_tck)
   );

   assign tap_adc_start = pin_sync[TAP_BASE];
   assign tap_dac_load  = pin_sync[TAP_BASE+1];
   assign tap_tmr0      = pin_sync[TAP_BASE+2];
   assign tap_tmr1      = pin_sync[TAP_BASE+3];

   assert_no_drive_and_pull_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & pad_pu) == '0);
   assert_shared_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !released |-> (pad_oe[SHARED_PINS-1:0] == SHARED_PINS'(1)
                     && pad_pu[SHARED_PINS-1:0] == '0));
   assert_released_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      released |-> (jtag_tms && jtag_tdi && !jtag_tck));
endmodule

// File: tb/tb_gpio_mux_port.sv
module tb_gpio_mux_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_mod = '0;
   logic [3:0]  bus_idx = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  pad_in = 8'h00;
   logic [7:0]  pad_out, pad_oe, pad_pu;
   logic        jtag_tdo = 1'b0;
   logic        jtag_tms, jtag_tdi, jtag_tck;
   logic        tap_adc_start, tap_dac_load, tap_tmr0, tap_tmr1;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   gpio_mux_port dut (
      .clk(clk), .rst_n(rst_n), .bus_mod(bus_mod), .bus_idx(bus_idx),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
      .jtag_tdo(jtag_tdo), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi),
      .jtag_tck(jtag_tck), .tap_adc_start(tap_adc_start),
      .tap_dac_load(tap_dac_load), .tap_tmr0(tap_tmr0), .tap_tmr1(tap_tmr1)
   );

   // {index, write data, expected read-back}
   localparam logic [35:0] VEC [0:6] = '{
      {4'd0, 16'hAB12, 16'h0012},
      {4'd0, 16'hFFFF, 16'h00FF},
      {4'd1, 16'h1234, 16'h0034},
      {4'd1, 16'hFF00, 16'h0000},
      {4'd3, 16'hFFFE, 16'h0000},
      {4'd3, 16'h0001, 16'h0001},
      {4'd3, 16'h0000, 16'h0000}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] idx, input logic [15:0] data);
      @(negedge clk);
      bus_idx = idx; bus_wdata = data; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [3:0] idx, output logic [15:0] data);
      @(negedge clk);
      bus_idx = idx; bus_wr = 1'b0;
      #1;
      data = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(4'd0, r); chk("R2 odata reset", r, 16'h00FF);
      rd(4'd1, r); chk("R2 dir reset", r, 16'h0000);
      rd(4'd3, r); chk("R2 ctrl reset", r, 16'h0000);
      chk("R6 oe after reset", {8'h0, pad_oe}, 16'h0001);
      chk("R6 pu after reset", {8'h0, pad_pu}, 16'h00F0);
      chk("R6 out after reset", {8'h0, pad_out}, 16'h0000);

      // test-port passthrough
      @(negedge clk);
      pad_in = 8'h0A; jtag_tdo = 1'b1;
      #1;
      chk("R6 tms/tdi/tck", {13'h0, jtag_tms, jtag_tdi, jtag_tck}, 16'h0005);
      chk("R6 tdo to pad", {15'h0, pad_out[0]}, 16'h0001);

      // register table
      for (int i = 0; i < 7; i++) begin
         wr(VEC[i][35:32], VEC[i][31:16]);
         rd(VEC[i][35:32], r);
         chk($sformatf("R1 table row %0d", i), r, VEC[i][15:0]);
      end

      // all outputs while shared pins stay owned
      wr(4'd1, 16'h00FF);
      chk("R6 R3 oe", {8'h0, pad_oe}, 16'h00F1);
      chk("R3 out", {8'h0, pad_out}, 16'h00F1);
      chk("R3 pu", {8'h0, pad_pu}, 16'h0000);
      rd(4'd0, r); chk("R5 odata kept", r, 16'h00FF);
      wr(4'd0, 16'h005A);
      chk("R3 out pattern", {8'h0, pad_out}, 16'h0051);
      wr(4'd1, 16'h000F);
      chk("R4 oe inputs", {8'h0, pad_oe}, 16'h0001);
      chk("R4 pu from odata", {8'h0, pad_pu}, 16'h0050);
      chk("R4 out low", {8'h0, pad_out}, 16'h0001);
      rd(4'd0, r); chk("R5 odata kept 2", r, 16'h005A);

      // release shared pins
      wr(4'd3, 16'h0001);
      chk("R7 oe", {8'h0, pad_oe}, 16'h000F);
      chk("R7 out", {8'h0, pad_out}, 16'h000A);
      chk("R7 pu", {8'h0, pad_pu}, 16'h0050);
      chk("R7 idle levels", {13'h0, jtag_tms, jtag_tdi, jtag_tck}, 16'h0006);

      // synchronizer latency
      @(negedge clk);
      pad_in = 8'h3C; bus_idx = 4'd2; bus_wr = 1'b0;
      @(negedge clk); #1;
      chk("R8 one edge old", bus_rdata, 16'h000A);
      @(negedge clk); #1;
      chk("R8 two edges new", bus_rdata, 16'h003C);
      chk("R9 taps", {12'h0, tap_tmr1, tap_tmr0, tap_dac_load, tap_adc_start}, 16'h0003);
      wr(4'd1, 16'h00FF);
      chk("R9 taps any dir", {12'h0, tap_tmr1, tap_tmr0, tap_dac_load, tap_adc_start}, 16'h0003);
      wr(4'd2, 16'hFFFF);
      rd(4'd2, r); chk("R8 write ignored", r, 16'h003C);
      rd(4'd0, r); chk("R8 odata untouched", r, 16'h005A);

      // unmapped and foreign accesses
      rd(4'd5, r); chk("R10 unmapped read", r, 16'h0000);
      wr(4'd5, 16'h0000);
      rd(4'd0, r); chk("R10 unmapped write", r, 16'h005A);
      bus_mod = 4'd1;
      rd(4'd0, r); chk("R10 foreign read", r, 16'h0000);
      wr(4'd0, 16'h0000);
      bus_mod = 4'd0;
      rd(4'd0, r); chk("R10 foreign write", r, 16'h005A);

      // reset again
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(4'd0, r); chk("R2 odata re-reset", r, 16'h00FF);
      rd(4'd3, r); chk("R2 ctrl re-reset", r, 16'h0000);
      chk("R6 oe re-reset", {8'h0, pad_oe}, 16'h0001);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule